// File: doc/BRIEF.md
# Edge-Aligned PWM Timer

This block is a free-running up-counter shared by a parameterised set of compare channels. The counter steps from zero up to a programmable modulo value and then reloads zero, so the period is one more than the modulo. Each wrap raises a sticky overflow flag. Each channel compares the count with its own compare value. A match raises that channel's sticky flag, and also its interrupt line when the channel's interrupt enable is set. The channel output is driven by a two-bit drive-select field.

Software configures the block through a one-cycle register write port: `wr_en`, `wr_addr` and `wr_data`. Flags are cleared by per-flag write-one strobes. All control and status pins are plain levels. No data streams through the block, so there is no valid/ready handshake and no back-pressure. The modulo and compare values pass through shadow registers and only take effect at a wrap, so a period is never cut short or given an extra edge.

Drive select has three behaviours. Value 00 leaves the output untouched. Value 10 gives a high-true pulse: high from the wrap, low from the match. Any value with bit 0 set gives a low-true pulse: low from the wrap, high from the match. Because every channel starts its period from the same wrap, the leading edges of all outputs line up.

Top module: `pwm_edge_timer`

## Requirements
- R1: The count runs 0, 1, …, MOD and then 0 again, so the period is MOD+1 clocks. The output of a high-true channel rises once per period, and its rises are MOD+1 clocks apart.
- R2: `ovf_flag_o` goes to 1 in the cycle in which the count holds zero after a wrap.
- R3: Flags stay set until cleared. A one on `ovf_clr` or `ch_clr[n]` at a clock edge clears the flag at that edge. If a set event falls on the same edge, the flag stays 1.
- R4: `ch_flag_o[n]` goes to 1 in the cycle in which the count equals the active compare value of channel n.
- R5: `ch_irq_o[n]` is 1 exactly when `ch_flag_o[n]` is 1 and the channel's interrupt enable (control bit 2) is 1.
- R6: With drive select 2'b10, the output is high from count 0 until the count reaches the compare value, and low from there to MOD. With MOD=8 and compare=5, it is high for counts 0–4 and low for counts 5–8.
- R7: When drive select bit 0 is 1, bit 1 is ignored. The output is then low from count 0 and high from the count that equals the compare value to MOD.
- R8: With drive select 2'b00, the output keeps its last value. The channel flag is still set on a match.
- R9: If the wrap and the match fall on the same count (compare value 0), the match level wins, so the output never leaves the match level. A compare value above MOD never matches: the output stays at its wrap level and the flag is not set.
- R10: Writes to MOD and to compare values go to shadow registers and take effect at the next wrap. Writes to a control register take effect at the next clock edge.
- R11: While `rst_n` is low, all outputs and flags are 0. MOD, the compare values, the count and the control registers reset to 0.
- R12: All channels use the same count. At the count-0 cycle, a high-true output is rising in the same cycle as a low-true output is falling.
- R13: Register addresses: 0 is MOD; 2n+1 is the compare value of channel n; 2n+2 is the control of channel n, with bits [1:0] the drive select and bit 2 the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | ADDR_W | Register address (see R13) |
| wr_data | input | CNT_W | Register write data |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| ch_clr | input | NCH | Write-one clear of each channel flag |
| pwm_o | output | NCH | Channel outputs |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ch_flag_o | output | NCH | Sticky channel match flags |
| ch_irq_o | output | NCH | Channel interrupt lines |

## Verification
The bench times flag clears so that they land on the very edge of a wrap or a match. A design that let the clear win would show a dropped flag there. It rewrites a compare value in the middle of a period and checks that the current period still uses the old edge. A design without shadow registers would move that edge early or cut a glitch into the output. It also drives compare values of 0 and of more than MOD. Getting the wrap-versus-match priority wrong gives a one-clock spike at every wrap, and a missing range check sets a flag that should stay clear. The disabled drive mode and the ignored select bit are exercised as well; a mistake there shows as an output that keeps toggling or as the wrong pulse polarity.

// File: rtl/pwm_edge_pkg.sv
`timescale 1ns/1ps
package pwm_edge_pkg;

  localparam int CTRL_W = 3;

  typedef struct packed {
    logic       irq_en;
    logic [1:0] sel;
  } ch_ctrl_t;

  typedef enum logic [1:0] {
    DRIVE_NONE,
    DRIVE_HIGH_TRUE,
    DRIVE_LOW_TRUE
  } drive_e;

  function automatic drive_e decode_sel(input logic [1:0] s);
    if (s[0])      return DRIVE_LOW_TRUE;
    else if (s[1]) return DRIVE_HIGH_TRUE;
    else           return DRIVE_NONE;
  endfunction

endpackage

// File: rtl/pwm_period_ctr.sv
`timescale 1ns/1ps
module pwm_period_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_wr_i,
  input  logic [CNT_W-1:0] mod_wdata_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             load_o,
  output logic             ovf_flag_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mod_act_q;
  logic [CNT_W-1:0] mod_shd_q;
  logic             ovf_q;
  logic             wrap;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    wrap  = (cnt_q == mod_act_q);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      mod_act_q <= '0;
      mod_shd_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (wrap)     mod_act_q <= mod_shd_q;
      if (mod_wr_i) mod_shd_q <= mod_wdata_i;
      ovf_q <= wrap | (ovf_q & ~ovf_clr_i);
    end
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;
  assign load_o     = wrap;
  assign ovf_flag_o = ovf_q;

  // count never runs past the active modulo
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= mod_act_q);

  // a non-zero count always follows its predecessor by one
  assert_cnt_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // overflow flag rises only at the zero count
  assert_ovf_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (cnt_q == '0));

endmodule

// File: rtl/pwm_cmp_channel.sv
`timescale 1ns/1ps
module pwm_cmp_channel
  import pwm_edge_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr_i,
  input  logic             ctrl_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             flag_clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  input  logic             load_i,
  output logic             pwm_o,
  output logic             flag_o,
  output logic             irq_o
);

  ch_ctrl_t         ctrl_q;
  logic [CNT_W-1:0] cmp_shd_q;
  logic [CNT_W-1:0] cmp_act_q;
  logic             pwm_q;
  logic             flag_q;
  logic [CNT_W-1:0] cmp_use;
  logic             hit;
  drive_e           drv;
  logic             pwm_d;

  always_comb begin
    cmp_use = load_i ? cmp_shd_q : cmp_act_q;
    hit     = (cnt_next_i == cmp_use);
    drv     = decode_sel(ctrl_q.sel);
    pwm_d   = pwm_q;
    unique case (drv)
      DRIVE_HIGH_TRUE: begin
        if (load_i) pwm_d = 1'b1;
        if (hit)    pwm_d = 1'b0;
      end
      DRIVE_LOW_TRUE: begin
        if (load_i) pwm_d = 1'b0;
        if (hit)    pwm_d = 1'b1;
      end
      default: pwm_d = pwm_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      cmp_shd_q <= '0;
      cmp_act_q <= '0;
      pwm_q     <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      cmp_act_q <= cmp_use;
      if (cmp_wr_i)  cmp_shd_q <= wdata_i;
      if (ctrl_wr_i) ctrl_q    <= ch_ctrl_t'(wdata_i[CTRL_W-1:0]);
      pwm_q  <= pwm_d;
      flag_q <= hit | (flag_q & ~flag_clr_i);
    end
  end

  assign pwm_o  = pwm_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ctrl_q.irq_en;

  // flag rises only in the cycle the count equals the active compare
  assert_flag_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (cnt_i == cmp_act_q));

  // high-true output rises only at the start of a period
  assert_high_rise_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drv == DRIVE_HIGH_TRUE && $past(drv) == DRIVE_HIGH_TRUE && $rose(pwm_q))
      |-> (cnt_i == '0));

  // low-true output falls only at the start of a period
  assert_low_fall_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drv == DRIVE_LOW_TRUE && $past(drv) == DRIVE_LOW_TRUE && $fell(pwm_q))
      |-> (cnt_i == '0));

  // disabled drive keeps the output frozen
  assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv == DRIVE_NONE && $past(drv) == DRIVE_NONE) |-> $stable(pwm_q));

endmodule

// File: rtl/pwm_edge_timer.sv
`timescale 1ns/1ps
module pwm_edge_timer #(
  parameter int CNT_W  = 8,
  parameter int NCH    = 2,
  parameter int ADDR_W = $clog2(2*NCH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              ovf_clr,
  input  logic [NCH-1:0]    ch_clr,
  output logic [NCH-1:0]    pwm_o,
  output logic              ovf_flag_o,
  output logic [NCH-1:0]    ch_flag_o,
  output logic [NCH-1:0]    ch_irq_o
);

  localparam logic [ADDR_W-1:0] MOD_ADDR = '0;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;
  logic             load;
  logic             mod_wr;

  assign mod_wr = wr_en && (wr_addr == MOD_ADDR);

  pwm_period_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mod_wr_i   (mod_wr),
    .mod_wdata_i(wr_data),
    .ovf_clr_i  (ovf_clr),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next),
    .load_o     (load),
    .ovf_flag_o (ovf_flag_o)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] CMP_ADDR  = ADDR_W'(2*n + 1);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2*n + 2);
    logic cmp_wr;
    logic ctrl_wr;
    assign cmp_wr  = wr_en && (wr_addr == CMP_ADDR);
    assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);

    pwm_cmp_channel #(.CNT_W(CNT_W)) ch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmp_wr_i  (cmp_wr),
      .ctrl_wr_i (ctrl_wr),
      .wdata_i   (wr_data),
      .flag_clr_i(ch_clr[n]),
      .cnt_i     (cnt),
      .cnt_next_i(cnt_next),
      .load_i    (load),
      .pwm_o     (pwm_o[n]),
      .flag_o    (ch_flag_o[n]),
      .irq_o     (ch_irq_o[n])
    );
  end

  // every channel and the overflow flag see the same wrap
  assert_shared_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag_o) |-> (cnt == '0));

endmodule

// File: tb/pwm_edge_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_edge_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 8;
  localparam int NCH    = 2;
  localparam int ADDR_W = $clog2(2*NCH+1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [CNT_W-1:0]  wr_data;
  logic              ovf_clr;
  logic [NCH-1:0]    ch_clr;
  logic [NCH-1:0]    pwm_o;
  logic              ovf_flag_o;
  logic [NCH-1:0]    ch_flag_o;
  logic [NCH-1:0]    ch_irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_edge_timer #(.CNT_W(CNT_W), .NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ovf_clr(ovf_clr), .ch_clr(ch_clr), .pwm_o(pwm_o), .ovf_flag_o(ovf_flag_o),
    .ch_flag_o(ch_flag_o), .ch_irq_o(ch_irq_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_modA, m_modS, m_ovf;
  int m_cmpA[NCH], m_cmpS[NCH], m_ctrl[NCH], m_pwm[NCH], m_flag[NCH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_modA = 0; m_modS = 0; m_ovf = 0;
      for (int c = 0; c < NCH; c++) begin
        m_cmpA[c] = 0; m_cmpS[c] = 0; m_ctrl[c] = 0; m_pwm[c] = 0; m_flag[c] = 0;
      end
    end else begin
      int wrap, nxt, use_v, hit, sel, lowt;
      wrap = (m_cnt == m_modA);
      nxt  = wrap ? 0 : m_cnt + 1;
      m_ovf = (wrap || (m_ovf && !ovf_clr)) ? 1 : 0;
      for (int c = 0; c < NCH; c++) begin
        use_v = wrap ? m_cmpS[c] : m_cmpA[c];
        hit   = (nxt == use_v);
        sel   = m_ctrl[c] & 3;
        lowt  = sel & 1;
        if (sel != 0) begin
          if (wrap) m_pwm[c] = lowt ? 0 : 1;
          if (hit)  m_pwm[c] = lowt ? 1 : 0;
        end
        m_flag[c] = (hit || (m_flag[c] && !ch_clr[c])) ? 1 : 0;
        m_cmpA[c] = use_v;
      end
      if (wrap) m_modA = m_modS;
      m_cnt = nxt;
      if (wr_en) begin
        if (wr_addr == 0) m_modS = int'(wr_data);
        else if (wr_addr[0]) m_cmpS[(int'(wr_addr) - 1) / 2] = int'(wr_data);
        else m_ctrl[(int'(wr_addr) - 2) / 2] = int'(wr_data) & 7;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++) begin
        check(pwm_o[c] == m_pwm[c][0], ((m_ctrl[c] & 1) != 0) ? "R7" : "R6",
              "model pwm", int'(pwm_o[c]), m_pwm[c]);
        check(ch_flag_o[c] == m_flag[c][0], "R4", "model channel flag",
              int'(ch_flag_o[c]), m_flag[c]);
        check(ch_irq_o[c] == (m_flag[c][0] & m_ctrl[c][2]), "R5", "model irq",
              int'(ch_irq_o[c]), m_flag[c] & (m_ctrl[c] >> 2));
      end
      check(ovf_flag_o == m_ovf[0], "R2", "model overflow flag", int'(ovf_flag_o), m_ovf);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_cnt(input int v);
    do step(); while (m_cnt != v);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = CNT_W'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic pulse_ovf();
    ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
  endtask

  task automatic pulse_ch(input int c);
    ch_clr[c] = 1'b1; step(); ch_clr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int hi0, hi1, gap, prev;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ovf_clr = 1'b0; ch_clr = '0;
    repeat (3) step();
    // R11: reset state
    check(pwm_o == '0, "R11", "pwm in reset", int'(pwm_o), 0);
    check(ovf_flag_o == 1'b0, "R11", "overflow flag in reset", int'(ovf_flag_o), 0);
    check(ch_flag_o == '0 && ch_irq_o == '0, "R11", "channel flags/irq in reset",
          int'(ch_flag_o) + int'(ch_irq_o), 0);
    rst_n = 1'b1;

    // R13 map: MOD=8, ch0 compare 5 high-true no irq, ch1 compare 3 sel=11 irq on
    wr(0, 8); wr(1, 5); wr(2, 3'b010); wr(3, 3); wr(4, 3'b111);
    wait_cnt(0); wait_cnt(0);

    // R6 / R7 / R12: one period of both outputs
    check(pwm_o[0] == 1'b1 && pwm_o[1] == 1'b0, "R12", "aligned edges at count 0",
          int'(pwm_o), 1);
    hi0 = 0; hi1 = 0;
    for (int i = 0; i < 9; i++) begin
      if (pwm_o[0]) hi0++;
      if (pwm_o[1]) hi1++;
      step();
    end
    check(hi0 == 5, "R6", "high-true high cycles", hi0, 5);
    check(hi1 == 6, "R7", "low-true high cycles (bit1 ignored)", hi1, 6);

    // R1: spacing of rising edges
    wait_cnt(0);
    gap = 0; prev = 1;
    do begin
      prev = int'(pwm_o[0]); step(); gap++;
    end while (!(pwm_o[0] && prev == 0));
    check(gap == 9, "R1", "period in clocks", gap, 9);

    // R3: clear away from a set, then clear on the wrap edge
    wait_cnt(3); pulse_ovf();
    check(ovf_flag_o == 1'b0, "R3", "overflow cleared", int'(ovf_flag_o), 0);
    wait_cnt(8); pulse_ovf();
    check(ovf_flag_o == 1'b1, "R3", "set beats clear at wrap", int'(ovf_flag_o), 1);
    wait_cnt(4); pulse_ch(0);
    check(ch_flag_o[0] == 1'b1, "R3", "set beats clear at match", int'(ch_flag_o[0]), 1);

    // R4: flag rises exactly at the compare count
    wait_cnt(6); pulse_ch(0);
    wait_cnt(4);
    check(ch_flag_o[0] == 1'b0, "R4", "flag before match", int'(ch_flag_o[0]), 0);
    step();
    check(ch_flag_o[0] == 1'b1, "R4", "flag at match", int'(ch_flag_o[0]), 1);

    // R5: irq gated by enable
    check(ch_irq_o[0] == 1'b0, "R5", "irq masked ch0", int'(ch_irq_o[0]), 0);
    check(ch_irq_o[1] == ch_flag_o[1] && ch_flag_o[1], "R5", "irq enabled ch1",
          int'(ch_irq_o[1]), 1);

    // R10: mid-period compare write waits for the wrap
    wait_cnt(1); wr(1, 2); step();
    check(pwm_o[0] == 1'b1, "R10", "old compare still active at count 3", int'(pwm_o[0]), 1);
    wait_cnt(3);
    check(pwm_o[0] == 1'b0, "R10", "new compare active next period", int'(pwm_o[0]), 0);

    // R9: compare 0 -> match wins over wrap
    wr(1, 0); wait_cnt(0);
    hi0 = 0;
    for (int i = 0; i < 9; i++) begin if (pwm_o[0]) hi0++; step(); end
    check(hi0 == 0, "R9", "compare 0 high cycles", hi0, 0);

    // R9: compare above MOD never matches
    wr(1, 200); wait_cnt(0); wait_cnt(1); pulse_ch(0);
    hi0 = 0; hi1 = 0;
    for (int i = 0; i < 9; i++) begin
      if (pwm_o[0]) hi0++;
      if (ch_flag_o[0]) hi1++;
      step();
    end
    check(hi0 == 9, "R9", "compare above MOD high cycles", hi0, 9);
    check(hi1 == 0, "R9", "compare above MOD flag cycles", hi1, 0);

    // R8: disabled drive holds the output but still flags
    wr(1, 5); wait_cnt(0); wait_cnt(1); pulse_ch(0); wr(2, 3'b000);
    hi0 = 0;
    for (int i = 0; i < 18; i++) begin if (pwm_o[0]) hi0++; step(); end
    check(hi0 == 18, "R8", "output held high while disabled", hi0, 18);
    check(ch_flag_o[0] == 1'b1, "R8", "flag still set while disabled", int'(ch_flag_o[0]), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule